// File: doc/BRIEF.md
# System Configuration Register Block

This block is a 4 KB window of control and identification registers for a board-level system controller, reached over a simple 32-bit register bus with single-cycle accesses. Writes take effect at the clock edge on which the select and write strobes are high; read data is returned combinationally during a read access. It holds a general control word (bit 0 drives a remap output), an LED word (low byte drives eight LED outputs), a switch word that reads as zero, a clock-lock register and three fixed identification words set by parameters.

Its main mechanism is an indirect configuration channel onto a small bank of oscillator-frequency registers. Software places a value in the outgoing-data register, then writes the channel control word with a function code, a device number, a direction flag and a start bit. In the same edge the channel performs the transfer and moves a three-state status machine: CH_IDLE (status 0), CH_DONE (done only) or CH_FAIL (done and error). The transitions are as follows. Any control write without start goes to CH_IDLE. A control write with start and a valid target goes to CH_DONE. A control write with start and an invalid target goes to CH_FAIL. Every other cycle holds the state. The lock register combines software mask bits with per-loop lock inputs into a single summary bit.

Top module: `sysctl_regs`

## Requirements
- R1: After reset: general word, LED word, outgoing data, returned data and status read 0; channel control reads 0x00100000; lock register reads 0xFFFF0001 while all lock inputs are high; LED and remap outputs are 0.
- R2: General word (0x000) and LED word (0x004) read back the last value written; led_out equals LED word bits [7:0] and remap_out equals general word bit 0.
- R3: A write to channel control (0x0A8) stores the value with bits 31, [29:26] and [19:12] forced to 0, so it reads back as value AND 0x43F00FFF.
- R4: Every write to channel control clears status (0x0AC); a write with start (bit 31) clear leaves status at 0.
- R5: A write with start set, function code (bits [25:20]) equal to 1 and device number (bits [11:0]) below 3 sets status to 0x1 (bit 0 done, bit 1 error clear).
- R6: A write with start set and any other function code or device number sets status to 0x3.
- R7: A valid start with bit 30 set copies outgoing data (0x0A4) into the selected oscillator register; a valid start with bit 30 clear copies the selected oscillator register into returned data (0x0A0).
- R8: An errored start changes neither returned data nor any oscillator register.
- R9: Oscillator registers 0, 1 and 2 reset to 50000000, 24576000 and 25000000.
- R10: Lock register (0x100): only bits [31:24] (mask) are writable, reset 0xFF; bits [23:16] show lock_in; bit 0 is the OR of lock_in ANDed with the mask; bits [15:1] read 0.
- R11: The fixed words at 0x010, 0xFF8 and 0xFFC return their parameters, 0x00C reads 0, undefined offsets read 0, and writes to these offsets and to returned data (0x0A0) change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Access strobe |
| bus_wr | input | 1 | 1 = write access, 0 = read access |
| bus_addr | input | 12 | Byte offset within the window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, 0 outside read accesses |
| lock_in | input | 8 | Per-loop lock indications |
| led_out | output | 8 | LED drive |
| remap_out | output | 1 | Memory remap control |

## Verification
The hardest outcome to reach is the one where an errored transfer must leave state untouched. The returned-data register and the oscillator bank are only visible through further channel transfers, so the bench keeps its own copy of both. It sweeps all 64 function codes against a set of devices that includes upper-bit aliases such as 0x101 and 0xFFF. After each write transfer it immediately issues a read transfer to the same target. This catches a corrupting write, a wrong device decode or a stale returned value.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;

    localparam int ADDR_W = 12;
    localparam int DATA_W = 32;
    localparam int LOCK_N = 8;

    localparam logic [ADDR_W-1:0] OFS_GEN    = 12'h000;
    localparam logic [ADDR_W-1:0] OFS_LED    = 12'h004;
    localparam logic [ADDR_W-1:0] OFS_SW     = 12'h00C;
    localparam logic [ADDR_W-1:0] OFS_FIXCFG = 12'h010;
    localparam logic [ADDR_W-1:0] OFS_RTN    = 12'h0A0;
    localparam logic [ADDR_W-1:0] OFS_DOUT   = 12'h0A4;
    localparam logic [ADDR_W-1:0] OFS_CTRL   = 12'h0A8;
    localparam logic [ADDR_W-1:0] OFS_STAT   = 12'h0AC;
    localparam logic [ADDR_W-1:0] OFS_LOCK   = 12'h100;
    localparam logic [ADDR_W-1:0] OFS_IDA    = 12'hFF8;
    localparam logic [ADDR_W-1:0] OFS_IDB    = 12'hFFC;

    localparam int BIT_START = 31;
    localparam int BIT_WRITE = 30;
    localparam int FN_LSB    = 20;
    localparam int FN_W      = 6;
    localparam int DEV_W     = 12;

    localparam logic [DATA_W-1:0] CTRL_KEEP  = 32'h43F0_0FFF;
    localparam logic [DATA_W-1:0] CTRL_RESET = 32'h0010_0000;
    localparam logic [FN_W-1:0]   FN_OSC     = 6'd1;

    typedef enum logic [1:0] {
        CH_IDLE = 2'b00,
        CH_DONE = 2'b01,
        CH_FAIL = 2'b11
    } chan_state_t;

endpackage

// File: rtl/sysctl_osc_bank.sv
module sysctl_osc_bank #(
    parameter int NUM_OSC = 3,
    parameter int IDX_W = 2,
    parameter logic [NUM_OSC*32-1:0] OSC_INIT = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [IDX_W-1:0] sel,
    input  logic [31:0]      wdata,
    output logic [31:0]      rd_val
);

    logic [31:0] osc_q [NUM_OSC];

    for (genvar g = 0; g < NUM_OSC; g++) begin : g_osc
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                osc_q[g] <= OSC_INIT[g*32 +: 32];
            end else if (we && sel == IDX_W'(g)) begin
                osc_q[g] <= wdata;
            end
        end

        AST_OSC_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
            (we && sel == IDX_W'(g)) |=> osc_q[g] == $past(wdata)); // R7
    end

    always_comb begin
        rd_val = '0;
        for (int i = 0; i < NUM_OSC; i++) begin
            if (sel == IDX_W'(i)) rd_val = osc_q[i];
        end
    end

endmodule

// File: rtl/sysctl_chan.sv
module sysctl_chan
    import sysctl_pkg::*;
#(
    parameter int NUM_OSC = 3,
    parameter int IDX_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctrl_we,
    input  logic [31:0]      wdata,
    input  logic [31:0]      osc_rd,
    output logic [31:0]      ctrl_q,
    output logic [31:0]      stat_q,
    output logic [31:0]      rtn_q,
    output logic             osc_we,
    output logic [IDX_W-1:0] osc_sel
);

    chan_state_t st_q, st_d;
    logic [FN_W-1:0]  fn;
    logic [DEV_W-1:0] dev;
    logic             target_ok;
    logic             go;
    logic             rtn_ld;

    assign fn        = wdata[FN_LSB +: FN_W];
    assign dev       = wdata[DEV_W-1:0];
    assign target_ok = (fn == FN_OSC) && (dev < DEV_W'(NUM_OSC));
    assign go        = ctrl_we && wdata[BIT_START];
    assign osc_sel   = dev[IDX_W-1:0];
    assign osc_we    = go && wdata[BIT_WRITE] && target_ok;
    assign rtn_ld    = go && !wdata[BIT_WRITE] && target_ok;

    // next state
    always_comb begin
        st_d = st_q;
        if (ctrl_we) begin
            if (!wdata[BIT_START]) st_d = CH_IDLE;
            else if (target_ok)    st_d = CH_DONE;
            else                   st_d = CH_FAIL;
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= CH_IDLE;
        else        st_q <= st_d;
    end

    // status outputs from state
    always_comb begin
        stat_q = '0;
        unique case (st_q)
            CH_IDLE: stat_q[1:0] = 2'b00;
            CH_DONE: stat_q[1:0] = 2'b01;
            CH_FAIL: stat_q[1:0] = 2'b11;
            default: stat_q[1:0] = 2'b00;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= CTRL_RESET;
            rtn_q  <= '0;
        end else begin
            if (ctrl_we) ctrl_q <= wdata & CTRL_KEEP;
            if (rtn_ld)  rtn_q  <= osc_rd;
        end
    end

    AST_STAT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_we && !wdata[31]) |=> stat_q == 32'd0); // R4
    AST_GOOD_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_we && wdata[31] && wdata[25:20] == 6'd1 && wdata[11:0] < 12'(NUM_OSC))
        |=> stat_q == 32'd1); // R5
    AST_BAD_ERROR: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_we && wdata[31] && (wdata[25:20] != 6'd1 || wdata[11:0] >= 12'(NUM_OSC)))
        |=> stat_q == 32'd3); // R6
    AST_BAD_RTN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_we && wdata[31] && wdata[25:20] != 6'd1) |=> $stable(rtn_q)); // R8
    AST_START_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_we |=> !ctrl_q[31]); // R3

endmodule

// File: rtl/sysctl_lock.sv
module sysctl_lock
    import sysctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [LOCK_N-1:0] mask_wd,
    input  logic [LOCK_N-1:0] lk_in,
    output logic [31:0]       rd
);

    logic [LOCK_N-1:0] mask_q;
    logic              summary;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  mask_q <= '1;
        else if (we) mask_q <= mask_wd;
    end

    assign summary = |(lk_in & mask_q);
    assign rd      = {mask_q, lk_in, 15'd0, summary};

    AST_MASK_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> mask_q == $past(mask_wd)); // R10

endmodule

// File: rtl/sysctl_regs.sv
module sysctl_regs
    import sysctl_pkg::*;
#(
    parameter int NUM_OSC = 3,
    parameter logic [NUM_OSC*32-1:0] OSC_INIT = {32'd25000000, 32'd24576000, 32'd50000000},
    parameter logic [31:0] FIX_CFG = 32'h0000_0000,
    parameter logic [31:0] ID_A = 32'h0000_0000,
    parameter logic [31:0] ID_B = 32'h0000_0000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_sel,
    input  logic        bus_wr,
    input  logic [11:0] bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    input  logic [7:0]  lock_in,
    output logic [7:0]  led_out,
    output logic        remap_out
);

    localparam int IDX_W = (NUM_OSC > 1) ? $clog2(NUM_OSC) : 1;

    logic        wr_en;
    logic [31:0] gen_q, led_q, dout_q;
    logic [31:0] ctrl_q, stat_q, rtn_q, lock_rd, osc_rd;
    logic        osc_we;
    logic [IDX_W-1:0] osc_sel;

    assign wr_en = bus_sel && bus_wr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gen_q  <= '0;
            led_q  <= '0;
            dout_q <= '0;
        end else if (wr_en) begin
            if (bus_addr == OFS_GEN)  gen_q  <= bus_wdata;
            if (bus_addr == OFS_LED)  led_q  <= bus_wdata;
            if (bus_addr == OFS_DOUT) dout_q <= bus_wdata;
        end
    end

    assign led_out   = led_q[7:0];
    assign remap_out = gen_q[0];

    sysctl_chan #(.NUM_OSC(NUM_OSC), .IDX_W(IDX_W)) u_chan (
        .clk     (clk),
        .rst_n   (rst_n),
        .ctrl_we (wr_en && bus_addr == OFS_CTRL),
        .wdata   (bus_wdata),
        .osc_rd  (osc_rd),
        .ctrl_q  (ctrl_q),
        .stat_q  (stat_q),
        .rtn_q   (rtn_q),
        .osc_we  (osc_we),
        .osc_sel (osc_sel)
    );

    sysctl_osc_bank #(.NUM_OSC(NUM_OSC), .IDX_W(IDX_W), .OSC_INIT(OSC_INIT)) u_osc (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (osc_we),
        .sel    (osc_sel),
        .wdata  (dout_q),
        .rd_val (osc_rd)
    );

    sysctl_lock u_lock (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (wr_en && bus_addr == OFS_LOCK),
        .mask_wd (bus_wdata[31:24]),
        .lk_in   (lock_in),
        .rd      (lock_rd)
    );

    always_comb begin
        bus_rdata = '0;
        if (bus_sel && !bus_wr) begin
            case (bus_addr)
                OFS_GEN:    bus_rdata = gen_q;
                OFS_LED:    bus_rdata = led_q;
                OFS_SW:     bus_rdata = '0;
                OFS_FIXCFG: bus_rdata = FIX_CFG;
                OFS_RTN:    bus_rdata = rtn_q;
                OFS_DOUT:   bus_rdata = dout_q;
                OFS_CTRL:   bus_rdata = ctrl_q;
                OFS_STAT:   bus_rdata = stat_q;
                OFS_LOCK:   bus_rdata = lock_rd;
                OFS_IDA:    bus_rdata = ID_A;
                OFS_IDB:    bus_rdata = ID_B;
                default:    bus_rdata = '0;
            endcase
        end
    end

    AST_LED_PORT: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && bus_addr == OFS_LED) |=> led_out == $past(bus_wdata[7:0])); // R2
    AST_REMAP_PORT: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && bus_addr == OFS_GEN) |=> remap_out == $past(bus_wdata[0])); // R2

endmodule

// File: tb/sim_sysctl_regs.sv
module sim_sysctl_regs;

    localparam logic [31:0] FIXV = 32'h1234_5678;
    localparam logic [31:0] IDAV = 32'h0BAD_F00D;
    localparam logic [31:0] IDBV = 32'hC0DE_0042;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [7:0]  lock_in = 8'hFF;
    logic [7:0]  led_out;
    logic        remap_out;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    logic [31:0] osc_m [3];
    logic [31:0] rtn_m;

    always #2 clk = ~clk;

    sysctl_regs #(.FIX_CFG(FIXV), .ID_A(IDAV), .ID_B(IDBV)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .lock_in(lock_in), .led_out(led_out), .remap_out(remap_out)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        #1 bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    function automatic logic [11:0] dev_of(input int i);
        case (i)
            0: return 12'd0;
            1: return 12'd1;
            2: return 12'd2;
            3: return 12'd3;
            4: return 12'd4;
            5: return 12'd7;
            6: return 12'h101;
            default: return 12'hFFF;
        endcase
    endfunction

    initial begin
        #(4 * 150000);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        osc_m[0] = 32'd50000000; osc_m[1] = 32'd24576000; osc_m[2] = 32'd25000000;
        rtn_m = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(12'h000, v); chk("R1 gen", v, 32'h0);
        rd(12'h004, v); chk("R1 led", v, 32'h0);
        rd(12'h0A0, v); chk("R1 rtn", v, 32'h0);
        rd(12'h0A4, v); chk("R1 dout", v, 32'h0);
        rd(12'h0A8, v); chk("R1 ctrl", v, 32'h0010_0000);
        rd(12'h0AC, v); chk("R1 stat", v, 32'h0);
        rd(12'h100, v); chk("R1 lock", v, 32'hFFFF_0001);
        chk("R1 led_out", {24'd0, led_out}, 32'h0);
        chk("R1 remap", {31'd0, remap_out}, 32'h0);

        // R9 oscillator reset values through read transfers
        for (int d = 0; d < 3; d++) begin
            wr(12'h0A8, 32'h8010_0000 | d);
            rd(12'h0AC, v); chk("R9 stat", v, 32'h1);
            rd(12'h0A0, v); chk("R9 osc", v, osc_m[d]);
            rtn_m = osc_m[d];
        end

        // R2 general / LED words and their outputs
        for (int k = 0; k < 6; k++) begin
            logic [31:0] p;
            p = 32'h9E37_79B9 * (k + 1);
            wr(12'h000, p); wr(12'h004, ~p);
            rd(12'h000, v); chk("R2 gen", v, p);
            rd(12'h004, v); chk("R2 led", v, ~p);
            chk("R2 led_out", {24'd0, led_out}, {24'd0, ~p[7:0]});
            chk("R2 remap", {31'd0, remap_out}, {31'd0, p[0]});
        end

        // R3 / R4 stores without start
        wr(12'h0A8, 32'h7FFF_FFFF);
        rd(12'h0A8, v); chk("R3 mask", v, 32'h43F0_0FFF);
        rd(12'h0AC, v); chk("R4 clear", v, 32'h0);
        wr(12'h0A8, 32'h8010_0000);
        rtn_m = osc_m[0];
        rd(12'h0AC, v); chk("R5 done", v, 32'h1);
        wr(12'h0A8, 32'h0010_0001);
        rd(12'h0AC, v); chk("R4 clear after done", v, 32'h0);
        wr(12'h0A8, 32'hFFFF_FFFF);
        rd(12'h0A8, v); chk("R3 start zero", v, 32'h43F0_0FFF);
        rd(12'h0AC, v); chk("R6 all ones", v, 32'h3);
        wr(12'h0A8, 32'h0000_0000);
        rd(12'h0AC, v); chk("R4 clear after fail", v, 32'h0);

        // R5-R8 sweep over function codes and devices
        for (int f = 0; f < 64; f++) begin
            for (int i = 0; i < 8; i++) begin
                logic [11:0] d;
                logic [31:0] val, cw;
                bit ok;
                d = dev_of(i);
                val = 32'(f * 1000003 + i * 7919 + 5);
                ok = (f == 1) && (d < 12'd3);
                wr(12'h0A4, val);
                cw = 32'hC000_0000 | (32'(f) << 20) | {20'd0, d};
                wr(12'h0A8, cw);
                rd(12'h0A8, v); chk("R3 sweep", v, cw & 32'h43F0_0FFF);
                rd(12'h0AC, v); chk(ok ? "R5 write" : "R6 write", v, ok ? 32'h1 : 32'h3);
                if (ok) osc_m[d[1:0]] = val;
                wr(12'h0A8, 32'h8000_0000 | (32'(f) << 20) | {20'd0, d});
                rd(12'h0AC, v); chk(ok ? "R5 read" : "R6 read", v, ok ? 32'h1 : 32'h3);
                if (ok) rtn_m = osc_m[d[1:0]];
                rd(12'h0A0, v); chk(ok ? "R7 rtn" : "R8 rtn", v, rtn_m);
            end
        end
        for (int d = 0; d < 3; d++) begin
            wr(12'h0A8, 32'h8010_0000 | d);
            rd(12'h0A0, v); chk("R8 osc intact", v, osc_m[d]);
        end

        // R10 lock mask sweep
        for (int q = 0; q < 4; q++) begin
            logic [7:0] lk;
            lk = (q == 0) ? 8'hFF : (q == 1) ? 8'h00 : (q == 2) ? 8'h5A : 8'h81;
            lock_in = lk;
            for (int m = 0; m < 256; m++) begin
                logic [31:0] e;
                wr(12'h100, {8'(m), 24'hFFFFFF});
                e = {8'(m), lk, 15'd0, |(lk & 8'(m))};
                rd(12'h100, v); chk("R10 lock", v, e);
            end
        end
        lock_in = 8'hFF;

        // R11 fixed, switch and undefined offsets
        wr(12'h00C, 32'hFFFF_FFFF); wr(12'h010, 32'h0); wr(12'hFF8, 32'h1);
        wr(12'hFFC, 32'h2); wr(12'h0A0, 32'hDEAD_BEEF); wr(12'h200, 32'h5555_5555);
        wr(12'h008, 32'hAAAA_AAAA);
        rd(12'h00C, v); chk("R11 switch", v, 32'h0);
        rd(12'h010, v); chk("R11 fixcfg", v, FIXV);
        rd(12'hFF8, v); chk("R11 ida", v, IDAV);
        rd(12'hFFC, v); chk("R11 idb", v, IDBV);
        rd(12'h0A0, v); chk("R11 rtn ro", v, osc_m[2]);
        rd(12'h200, v); chk("R11 undef 200", v, 32'h0);
        rd(12'h008, v); chk("R11 undef 008", v, 32'h0);
        rd(12'h0AC, v); chk("R11 stat kept", v, 32'h1);

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule